// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Divider

This block generates the serial bit clock for a synchronous serial port acting as master. A reference clock is divided twice: first by an even prescale value in the range 2 to 254, then by one plus an 8-bit rate value. The overall ratio therefore spans from 2 to 254 × 256 reference cycles per bit. For example, a 3.6864 MHz reference with prescale 2 and rate 0 gives a 1.8432 Mbit/s bit clock. The output is a 50% duty-cycle serial clock level. Two single-cycle strobes mark its rising and falling edges, so a shift engine can launch and capture data on the same reference clock.

A small state machine tracks the port enable. It has two states. `ST_IDLE` is the reset state, entered whenever the enable is low. `ST_RUN` is entered when the enable is high. The transitions are IDLE_TO_RUN, taken when the enable is sampled high, and RUN_TO_IDLE, taken when the enable is sampled low. In `ST_IDLE` the counters are held cleared and the clock rests at the level given by the polarity input. The divider settings are captured on every cycle spent in `ST_IDLE`, which means they are taken only while the port is disabled. Changes made while running have no effect until the next disable.

Top module: `sclk_ratio_gen`

## Requirements
- R1: During reset, and afterwards while the enable stays low, `sclk` equals `polarity` and both strobes are low.
- R2: Whenever the port has been disabled for at least two cycles, `sclk` equals `polarity` and no strobe is produced.
- R3: The distance between successive same-direction edge strobes is P × (1 + rate) reference cycles. Here P is `prescale` with bit 0 cleared, and P is taken as 2 when that result is 0.
- R4: The serial clock has a 50% duty cycle: successive edge strobes are exactly P × (1 + rate) / 2 cycles apart.
- R5: Bit 0 of `prescale` has no effect: 5 divides exactly like 4, and 255 exactly like 254.
- R6: A `prescale` of 0 (or 1) divides like a prescale of 2.
- R7: With prescale 2 and rate 0, the bit period is 2 reference cycles, the smallest ratio.
- R8: With prescale 254 (or 255) and rate 255, the bit period is 65024 reference cycles, the largest ratio.
- R9: Changes to `prescale` and `rate` while the port is enabled leave the running period unchanged. They take effect after the port is disabled and enabled again.
- R10: `rise_stb` and `fall_stb` are each one cycle wide and never high together. They alternate, giving exactly one of each per bit period. `sclk` is 1 during a rise strobe and 0 during a fall strobe.
- R11: The first edge strobe comes on the (H+1)-th rising clock edge, counting the edge that samples `enable` high as the first, where H is half the period. It is a rise when `polarity` is 0 and a fall when `polarity` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Port enable; low holds the divider idle and opens configuration |
| polarity | input | 1 | Idle level of the serial clock |
| prescale | input | PRE_W | First-stage divisor; bit 0 ignored, 0 treated as 2 |
| rate | input | RATE_W | Second-stage value; divides by rate + 1 |
| sclk | output | 1 | Serial clock level |
| rise_stb | output | 1 | One-cycle strobe in the cycle `sclk` becomes 1 |
| fall_stb | output | 1 | One-cycle strobe in the cycle `sclk` becomes 0 |

## Verification
The assertions assume that `polarity` is held steady while the port runs, since the output level follows it directly. The check that the level changes only with a strobe is disabled in any cycle where polarity moved. The bench changes polarity, prescale and rate only at falling clock edges while the enable is low. The one exception is the deliberate mid-run change of prescale and rate that exercises R9. Random prescale values cover the whole 8-bit range, including odd values and zero. Random rate values are kept small so the run stays short, and the directed cases cover the two extreme ratios.

// File: rtl/sclk_ratio_pkg.sv
package sclk_ratio_pkg;

    // Enable-tracking states of the divider
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/sclk_prescale.sv
// First stage: emits a tick every half_div cycles while not cleared.
module sclk_prescale #(
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [HALF_W-1:0] half_div,
    output logic              tick
);
    logic [HALF_W-1:0] cnt_q;
    logic              at_end;

    assign at_end = (cnt_q == half_div - HALF_W'(1));
    assign tick   = !clear && at_end;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + HALF_W'(1);
        end
    end
endmodule

// File: rtl/sclk_rate_count.sv
// Second stage: counts rate_lim+1 prescale ticks per half bit period.
module sclk_rate_count #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate_lim,
    output logic              toggle
);
    logic [RATE_W-1:0] rcnt_q;

    assign toggle = tick && (rcnt_q == rate_lim);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rcnt_q <= '0;
        end else if (toggle) begin
            rcnt_q <= '0;
        end else if (tick) begin
            rcnt_q <= rcnt_q + RATE_W'(1);
        end
    end
endmodule

// File: rtl/sclk_ratio_gen.sv
module sclk_ratio_gen
    import sclk_ratio_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              polarity,
    input  logic [PRE_W-1:0]  prescale,
    input  logic [RATE_W-1:0] rate,
    output logic              sclk,
    output logic              rise_stb,
    output logic              fall_stb
);
    localparam int HALF_W = PRE_W - 1;

    div_state_e        st_q, st_d;
    logic              run_now;
    logic [HALF_W-1:0] half_in, half_eff;
    logic [HALF_W-1:0] cfg_half_q;
    logic [RATE_W-1:0] cfg_rate_q;
    logic              tick, toggle;
    logic              phase_q, rise_q, fall_q;

    // Prescale bit 0 dropped; zero half-divisor clamped to one (divide by 2)
    assign half_in  = prescale[PRE_W-1:1];
    assign half_eff = (half_in == '0) ? HALF_W'(1) : half_in;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic: IDLE_TO_RUN on enable, RUN_TO_IDLE on disable
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (enable)  st_d = ST_RUN;
            ST_RUN:  if (!enable) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    assign run_now = (st_q == ST_RUN);

    // Configuration capture, open only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_half_q <= HALF_W'(1);
            cfg_rate_q <= '0;
        end else if (!run_now) begin
            cfg_half_q <= half_eff;
            cfg_rate_q <= rate;
        end
    end

    sclk_prescale #(.HALF_W(HALF_W)) prescale_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!run_now),
        .half_div (cfg_half_q),
        .tick     (tick)
    );

    sclk_rate_count #(.RATE_W(RATE_W)) rate_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!run_now),
        .tick     (tick),
        .rate_lim (cfg_rate_q),
        .toggle   (toggle)
    );

    // Output process: clock phase and edge strobes
    always_ff @(posedge clk) begin
        if (!rst_n || !run_now) begin
            phase_q <= 1'b0;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            rise_q <= toggle && (phase_q == polarity);
            fall_q <= toggle && (phase_q != polarity);
            if (toggle) begin
                phase_q <= !phase_q;
            end
        end
    end

    assign sclk     = phase_q ^ polarity;
    assign rise_stb = rise_q;
    assign fall_stb = fall_q;
endmodule

// File: rtl/sclk_ratio_chk.sv
module sclk_ratio_chk #(
    parameter int HALF_W = 7,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              polarity,
    input  logic              sclk,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              run_now,
    input  logic [HALF_W-1:0] cfg_half_q,
    input  logic [RATE_W-1:0] cfg_rate_q
);
    assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_now |=> (sclk == polarity && !rise_stb && !fall_stb));

    assert_no_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

    assert_rise_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb);

    assert_fall_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);

    assert_rise_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> sclk);

    assert_fall_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> !sclk);

    assert_quiet_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_now && $past(run_now) && $stable(polarity) && !rise_stb && !fall_stb)
        |-> $stable(sclk));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_now |=> ($stable(cfg_half_q) && $stable(cfg_rate_q)));

    assert_half_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_now |-> (cfg_half_q != '0));
endmodule

bind sclk_ratio_gen sclk_ratio_chk #(.HALF_W(HALF_W), .RATE_W(RATE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .polarity   (polarity),
    .sclk       (sclk),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .run_now    (run_now),
    .cfg_half_q (cfg_half_q),
    .cfg_rate_q (cfg_rate_q)
);

// File: tb/sclk_ratio_gen_tb_top.sv
module sclk_ratio_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk      = 1'b0;
    logic       rst_n    = 1'b0;
    logic       enable   = 1'b0;
    logic       polarity = 1'b0;
    logic [7:0] prescale = 8'd2;
    logic [7:0] rate     = 8'd0;
    logic       sclk, rise_stb, fall_stb;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sclk_ratio_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .polarity (polarity),
        .prescale (prescale),
        .rate     (rate),
        .sclk     (sclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    function automatic int exp_period(input logic [7:0] p, input logic [7:0] r);
        int pe;
        pe = int'(p & 8'hFE);
        if (pe == 0) pe = 2;
        return pe * (int'(r) + 1);
    endfunction

    task automatic wait_edge(output int t, output bit was_rise);
        while (1) begin
            @(negedge clk);
            cyc++;
            if (rise_stb && fall_stb) check(1'b0, "R10 both strobes high", 1, 0);
            if (rise_stb || fall_stb) begin
                t        = cyc;
                was_rise = rise_stb;
                break;
            end
        end
    endtask

    task automatic run_case(input logic [7:0] p, input logic [7:0] r, input bit pol,
                            input bit chg, input string tag);
        int  n, h, t1, t2, t3;
        bit  k1, k2, k3;
        @(negedge clk);
        enable   = 1'b0;
        prescale = p;
        rate     = r;
        polarity = pol;
        repeat (3) @(negedge clk);
        check(sclk == pol && !rise_stb && !fall_stb, "R2 idle level",
              int'(sclk), int'(pol));
        enable = 1'b1;
        cyc    = 0;
        n = exp_period(p, r);
        h = n / 2;
        wait_edge(t1, k1);
        check(t1 == h + 1, "R11 first edge delay", t1, h + 1);
        check(k1 == (pol == 1'b0), "R11 first edge direction", int'(k1), int'(pol == 1'b0));
        if (chg) begin
            prescale = 8'd10;
            rate     = 8'd3;
        end
        wait_edge(t2, k2);
        check(t2 - t1 == h, "R4 half period", t2 - t1, h);
        check(k2 != k1, "R10 strobes alternate", int'(k2), int'(!k1));
        wait_edge(t3, k3);
        check(t3 - t1 == n, {tag, " bit period"}, t3 - t1, n);
        check(k3 == k1, "R10 one of each per period", int'(k3), int'(k1));
        if (h > 1) begin
            @(negedge clk);
            cyc++;
            check(!rise_stb && !fall_stb, "R10 strobe one cycle wide",
                  int'(rise_stb || fall_stb), 0);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R3 watchdog expired actual=%0d expected=0", WATCHDOG);
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0421));
        repeat (3) @(negedge clk);
        check(sclk == 1'b0 && !rise_stb && !fall_stb, "R1 reset state", int'(sclk), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sclk == 1'b0 && !rise_stb && !fall_stb, "R1 after reset", int'(sclk), 0);

        run_case(8'd2,   8'd0,   1'b0, 1'b0, "R7");
        run_case(8'd0,   8'd3,   1'b0, 1'b0, "R6");
        run_case(8'd1,   8'd0,   1'b1, 1'b0, "R6");
        run_case(8'd5,   8'd2,   1'b1, 1'b0, "R5");
        run_case(8'd4,   8'd2,   1'b0, 1'b0, "R3");
        run_case(8'd6,   8'd1,   1'b0, 1'b1, "R9");
        run_case(8'd10,  8'd3,   1'b1, 1'b0, "R9 after re-enable");
        for (int i = 0; i < 6; i++) begin
            logic [7:0] rp, rr;
            bit         rpol;
            rp   = 8'($urandom_range(0, 255));
            rr   = 8'($urandom_range(0, 7));
            rpol = 1'($urandom_range(0, 1));
            run_case(rp, rr, rpol, 1'b0, "R3");
        end
        run_case(8'd255, 8'd255, 1'b1, 1'b0, "R8");

        @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        check(sclk == polarity && !rise_stb && !fall_stb, "R2 final idle",
              int'(sclk), int'(polarity));
        report();
        $finish;
    end
endmodule